// File: doc/BRIEF.md
# Endpoint FIFO Access Port with Byte-Order Control

This block holds a transmit FIFO (host to serial engine, called IN) and a receive FIFO (serial engine to host, called OUT), each 64 bytes deep. A bus master reaches both through one data port. Each access moves either a single byte or a 16-bit word. Two global configuration bits set the byte order of word accesses. `cfg_wr_big` controls how a written word is split into the IN FIFO, and `cfg_rd_big` controls how two OUT bytes are combined into a read word. When both bits select big-endian, word transfers of an even length produce the same byte order as byte transfers.

The serial-engine side is a plain byte stream. It pops IN bytes, and it pushes OUT bytes together with packet-end and data-error strobes. A small receive state machine follows OUT packet boundaries with three states: `RX_IDLE`, `RX_FILL` and `RX_DONE`. Its transitions are:

- *start*: IDLE goes to FILL on an accepted byte.
- *grow*: FILL stays in FILL on an accepted byte.
- *close*: any state goes to DONE on a packet end, which latches the packet length.
- *restart*: DONE goes to FILL on an accepted byte.
- *clear*: any state goes to IDLE on `ctrl_clr`.

The block raises no transfer-request signal. Every data movement is started by the bus master or by the serial engine.

Top module: `epf_access_port`

## Requirements
- R1: A byte write (`host_word`=0) pushes `host_wdata[7:0]` into the IN FIFO. A byte read returns the OUT head byte in `host_rdata[7:0]` with bits 15:8 zero, valid from the clock edge that accepts the read.
- R2: A word write pushes two bytes. With `cfg_wr_big`=1, bits 15:8 enter the IN FIFO first. With `cfg_wr_big`=0, bits 7:0 enter first.
- R3: A word read pops two OUT bytes. With `cfg_rd_big`=1, the earlier byte is placed in bits 15:8. With `cfg_rd_big`=0, the earlier byte is placed in bits 7:0.
- R4: With both order bits at 1, a sequence of an even number of bytes written or read as words has the same FIFO order as the same sequence moved byte by byte.
- R5: A word read when exactly one OUT byte is stored returns that byte in the earlier-byte half (bits 15:8 for big-endian, 7:0 for little-endian), with zero in the other half, and pops only that byte.
- R6: `in_count` and `out_count` give FIFO occupancy from 0 to 64. Serial-engine pushes into a full OUT FIFO are dropped. A pop by the serial engine removes the byte on `sie_in_byte`.
- R7: A host write that does not fit is dropped and sets the sticky `in_overrun` flag. A byte write does not fit at 64 stored bytes, and a word write does not fit at 63 or more. `in_flush` empties the IN FIFO and clears `in_overrun`.
- R8: A host read while the OUT FIFO is empty pops nothing, loads zero into `host_rdata` and sets the sticky `out_underrun` flag.
- R9: `sie_out_err` sets the sticky `out_data_err` flag, which stays readable while the packet is unloaded. A single `ctrl_clr` strobe clears `out_data_err` and `out_underrun`, empties the OUT FIFO and returns the receive machine to `RX_IDLE`.
- R10: `out_pkt_ready` is high only in `RX_DONE`. `out_pkt_len` is the count of OUT bytes accepted since the previous packet end, and it is latched when `sie_out_end` arrives (including a byte accepted in the same cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe into the IN FIFO |
| host_rd | input | 1 | Host read strobe from the OUT FIFO |
| host_word | input | 1 | 1: 16-bit access, 0: 8-bit access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| cfg_wr_big | input | 1 | Write byte order, 1 = big-endian |
| cfg_rd_big | input | 1 | Read byte order, 1 = big-endian |
| ctrl_clr | input | 1 | Clear data error and underrun, flush OUT FIFO |
| in_flush | input | 1 | Flush IN FIFO and clear overrun |
| in_count | output | 8 | IN FIFO occupancy |
| in_overrun | output | 1 | Sticky dropped-write flag |
| sie_in_pop | input | 1 | Serial engine takes one IN byte |
| sie_in_byte | output | 8 | IN FIFO head byte |
| sie_in_avail | output | 1 | IN FIFO not empty |
| sie_out_push | input | 1 | Serial engine delivers one OUT byte |
| sie_out_byte | input | 8 | Delivered OUT byte |
| sie_out_end | input | 1 | OUT packet end strobe |
| sie_out_err | input | 1 | OUT packet bit-error strobe |
| out_count | output | 8 | OUT FIFO occupancy |
| out_pkt_len | output | 8 | Length of the last closed OUT packet |
| out_pkt_ready | output | 1 | Receive machine is in RX_DONE |
| out_data_err | output | 1 | Sticky received-data error flag |
| out_underrun | output | 1 | Sticky read-when-empty flag |

## Verification
Every result passes through exactly one register. Read data, occupancy counts, sticky flags, packet length and receive state all change on the edge that samples the strobe. `sie_in_byte` follows combinationally from the IN head pointer. The bench drives strobes just after a falling edge, lets one rising edge pass, and samples on the following falling edge. Each check therefore looks at the value produced by that single edge and by no other. The head byte offered to the serial engine is read before the pop strobe is driven.

// File: rtl/epf_pkg.sv
`timescale 1ns/1ps
package epf_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_DONE = 2'd2
    } rx_state_t;
endpackage

// File: rtl/epf_fifo.sv
`timescale 1ns/1ps
// Byte FIFO that can take or give up to two bytes per cycle.
// din[7:0] / head0 is the earlier byte; din[15:8] / head1 the later one.
module epf_fifo #(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [15:0]   din,
    input  logic [1:0]    pop_n,
    output logic [7:0]    head0,
    output logic [7:0]    head1,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [AW-1:0] wptr_nx1;
    logic [AW-1:0] rptr_nx1;

    assign wptr_nx1 = wptr + AW'(1);
    assign rptr_nx1 = rptr + AW'(1);

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_n != 2'd0) mem[wptr]     <= din[7:0];
            if (push_n == 2'd2) mem[wptr_nx1] <= din[15:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + AW'(push_n);
            rptr  <= rptr + AW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    assign head0 = mem[rptr];
    assign head1 = mem[rptr_nx1];

    // R6: occupancy never leaves 0..DEPTH
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6: the caller never pushes beyond the free space
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CW'(push_n) <= CW'(DEPTH) - count));
    // R8: the caller never pops more than is stored
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CW'(pop_n) <= count));
endmodule

// File: rtl/epf_rx_fsm.sv
`timescale 1ns/1ps
// Tracks receive packet boundaries and latches packet length.
module epf_rx_fsm
    import epf_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_ok,
    input  logic          pkt_end,
    output logic [CW-1:0] pkt_len,
    output logic          pkt_ready
);
    rx_state_t     state;
    rx_state_t     state_nx;
    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_cnt_inc;

    assign run_cnt_inc = run_cnt + CW'(push_ok);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (pkt_end) state_nx = RX_DONE;
                     else if (push_ok) state_nx = RX_FILL;
            RX_FILL: if (pkt_end) state_nx = RX_DONE;
            RX_DONE: if (pkt_end) state_nx = RX_DONE;
                     else if (push_ok) state_nx = RX_FILL;
            default: state_nx = RX_IDLE;
        endcase
        if (clr) state_nx = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            pkt_len <= '0;
        end else if (clr) begin
            run_cnt <= '0;
            pkt_len <= '0;
        end else if (pkt_end) begin
            run_cnt <= '0;
            pkt_len <= run_cnt_inc;
        end else begin
            run_cnt <= run_cnt_inc;
        end
    end

    assign pkt_ready = (state == RX_DONE);

    // R10: a packet end always lands in RX_DONE
    p_done_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !clr) |=> pkt_ready);
    // R9: clear always returns to idle
    p_clr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == RX_IDLE) && (pkt_len == '0));
endmodule

// File: rtl/epf_access_port.sv
`timescale 1ns/1ps
module epf_access_port #(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_word,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic          cfg_wr_big,
    input  logic          cfg_rd_big,
    input  logic          ctrl_clr,
    input  logic          in_flush,
    output logic [CW-1:0] in_count,
    output logic          in_overrun,
    input  logic          sie_in_pop,
    output logic [7:0]    sie_in_byte,
    output logic          sie_in_avail,
    input  logic          sie_out_push,
    input  logic [7:0]    sie_out_byte,
    input  logic          sie_out_end,
    input  logic          sie_out_err,
    output logic [CW-1:0] out_count,
    output logic [CW-1:0] out_pkt_len,
    output logic          out_pkt_ready,
    output logic          out_data_err,
    output logic          out_underrun
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // ---------------- IN side (host writes, engine reads) ----------------
    logic [CW-1:0] in_room;
    logic [CW-1:0] in_need;
    logic          in_fits;
    logic [1:0]    in_push_n;
    logic [1:0]    in_pop_n;
    logic [15:0]   in_din;
    logic [7:0]    in_head1_unused;

    assign in_room = FULL - in_count;
    assign in_need = host_word ? CW'(2) : CW'(1);
    assign in_fits = (in_need <= in_room);

    always_comb begin
        in_push_n = 2'd0;
        if (host_wr && !in_flush && in_fits) in_push_n = host_word ? 2'd2 : 2'd1;
        in_pop_n = (sie_in_pop && !in_flush && in_count != '0) ? 2'd1 : 2'd0;
        // earlier byte goes in din[7:0]
        if (host_word && cfg_wr_big) in_din = {host_wdata[7:0], host_wdata[15:8]};
        else                         in_din = host_wdata;
    end

    epf_fifo #(.DEPTH(DEPTH), .CW(CW)) u_in_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (in_flush),
        .push_n (in_push_n),
        .din    (in_din),
        .pop_n  (in_pop_n),
        .head0  (sie_in_byte),
        .head1  (in_head1_unused),
        .count  (in_count)
    );

    assign sie_in_avail = (in_count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           in_overrun <= 1'b0;
        else if (in_flush)                    in_overrun <= 1'b0;
        else if (host_wr && !in_fits)         in_overrun <= 1'b1;
    end

    // ---------------- OUT side (engine writes, host reads) ----------------
    logic          out_push_ok;
    logic [1:0]    out_pop_n;
    logic [7:0]    out_head0;
    logic [7:0]    out_head1;
    logic          out_empty;
    logic          out_pair;
    logic [15:0]   rd_word;

    assign out_empty   = (out_count == '0);
    assign out_pair    = (out_count >= CW'(2));
    assign out_push_ok = sie_out_push && !ctrl_clr && (out_count != FULL);

    always_comb begin
        out_pop_n = 2'd0;
        if (host_rd && !ctrl_clr && !out_empty)
            out_pop_n = (host_word && out_pair) ? 2'd2 : 2'd1;
    end

    always_comb begin
        if (out_empty)       rd_word = 16'h0000;
        else if (!host_word) rd_word = {8'h00, out_head0};
        else if (out_pair)   rd_word = cfg_rd_big ? {out_head0, out_head1}
                                                  : {out_head1, out_head0};
        else                 rd_word = cfg_rd_big ? {out_head0, 8'h00}
                                                  : {8'h00, out_head0};
    end

    epf_fifo #(.DEPTH(DEPTH), .CW(CW)) u_out_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (ctrl_clr),
        .push_n (out_push_ok ? 2'd1 : 2'd0),
        .din    ({8'h00, sie_out_byte}),
        .pop_n  (out_pop_n),
        .head0  (out_head0),
        .head1  (out_head1),
        .count  (out_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata   <= '0;
            out_underrun <= 1'b0;
            out_data_err <= 1'b0;
        end else if (ctrl_clr) begin
            out_underrun <= 1'b0;
            out_data_err <= 1'b0;
        end else begin
            if (host_rd)              host_rdata   <= rd_word;
            if (host_rd && out_empty) out_underrun <= 1'b1;
            if (sie_out_err)          out_data_err <= 1'b1;
        end
    end

    epf_rx_fsm #(.CW(CW)) u_rx_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctrl_clr),
        .push_ok   (out_push_ok),
        .pkt_end   (sie_out_end),
        .pkt_len   (out_pkt_len),
        .pkt_ready (out_pkt_ready)
    );

    // R7: a byte write into a full IN FIFO leaves it full and flags it
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !in_flush && !sie_in_pop && in_count == FULL)
        |=> (in_count == FULL) && in_overrun);
    // R7: overrun stays until flushed
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_overrun && !in_flush) |=> in_overrun);
    // R8: read on empty returns zero and flags underrun
    p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && out_count == '0 && !ctrl_clr)
        |=> out_underrun && (host_rdata == 16'h0000) && (out_count == '0));
    // R8: underrun stays until cleared
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_underrun && !ctrl_clr) |=> out_underrun);
    // R9: data error stays until cleared
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data_err && !ctrl_clr) |=> out_data_err);
    // R9: clear strobe empties the OUT FIFO and drops the error
    p_clr_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> (out_count == '0) && !out_data_err && !out_underrun);
    // R1: byte reads keep the upper half zero
    p_byte_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_word && !ctrl_clr) |=> (host_rdata[15:8] == 8'h00));
endmodule

// File: tb/epf_access_port_test.sv
`timescale 1ns/1ps
module epf_access_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0, host_word = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cfg_wr_big = 0, cfg_rd_big = 0;
    logic        ctrl_clr = 0, in_flush = 0;
    logic [7:0]  in_count;
    logic        in_overrun;
    logic        sie_in_pop = 0;
    logic [7:0]  sie_in_byte;
    logic        sie_in_avail;
    logic        sie_out_push = 0;
    logic [7:0]  sie_out_byte = '0;
    logic        sie_out_end = 0, sie_out_err = 0;
    logic [7:0]  out_count, out_pkt_len;
    logic        out_pkt_ready, out_data_err, out_underrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    epf_access_port uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_wr_big(cfg_wr_big), .cfg_rd_big(cfg_rd_big),
        .ctrl_clr(ctrl_clr), .in_flush(in_flush),
        .in_count(in_count), .in_overrun(in_overrun),
        .sie_in_pop(sie_in_pop), .sie_in_byte(sie_in_byte), .sie_in_avail(sie_in_avail),
        .sie_out_push(sie_out_push), .sie_out_byte(sie_out_byte),
        .sie_out_end(sie_out_end), .sie_out_err(sie_out_err),
        .out_count(out_count), .out_pkt_len(out_pkt_len),
        .out_pkt_ready(out_pkt_ready), .out_data_err(out_data_err),
        .out_underrun(out_underrun)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic word, input logic [15:0] d);
        host_wr = 1; host_word = word; host_wdata = d;
        tick;
        host_wr = 0; host_word = 0;
    endtask

    task automatic host_read(input logic word, output logic [15:0] d);
        host_rd = 1; host_word = word;
        tick;
        host_rd = 0; host_word = 0;
        d = host_rdata;
    endtask

    task automatic sie_pop(output logic [7:0] b);
        b = sie_in_byte;
        sie_in_pop = 1;
        tick;
        sie_in_pop = 0;
    endtask

    task automatic sie_push(input logic [7:0] b, input logic last, input logic err);
        sie_out_push = 1; sie_out_byte = b; sie_out_end = last; sie_out_err = err;
        tick;
        sie_out_push = 0; sie_out_end = 0; sie_out_err = 0;
    endtask

    task automatic pulse_clr;
        ctrl_clr = 1; tick; ctrl_clr = 0;
    endtask

    task automatic pulse_flush;
        in_flush = 1; tick; in_flush = 0;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] d;
        logic [15:0] w;
        logic [7:0]  seq [10];

        repeat (3) @(negedge clk);
        // Reset state
        check("R6 reset in_count", 32'(in_count), 0);
        check("R6 reset out_count", 32'(out_count), 0);
        check("R6 reset avail", 32'(sie_in_avail), 0);
        check("R1 reset rdata", 32'(host_rdata), 0);
        check("R10 reset ready", 32'(out_pkt_ready), 0);
        check("R7 reset overrun", 32'(in_overrun), 0);
        check("R8 reset underrun", 32'(out_underrun), 0);
        check("R9 reset err", 32'(out_data_err), 0);
        rst_n = 1;
        tick;

        // R1: byte writes delivered in order
        for (int k = 0; k < 16; k++) host_write(0, {8'hEE, 8'(8'h11 * k + 3)});
        check("R6 in_count after 16 byte writes", 32'(in_count), 16);
        for (int k = 0; k < 16; k++) begin
            sie_pop(b);
            check("R1 byte write order", 32'(b), 32'(8'(8'h11 * k + 3)));
        end
        check("R6 in_count drained", 32'(in_count), 0);

        // R2: word write split by both orders, several patterns
        for (int be = 0; be < 2; be++) begin
            cfg_wr_big = be[0];
            for (int k = 0; k < 8; k++) begin
                w = 16'h1234 + 16'(k) * 16'h2F1D;
                host_write(1, w);
                check("R2 word write count", 32'(in_count), 2);
                sie_pop(b);
                check("R2 word write first byte", 32'(b), 32'(be ? w[15:8] : w[7:0]));
                sie_pop(b);
                check("R2 word write second byte", 32'(b), 32'(be ? w[7:0] : w[15:8]));
            end
        end

        // R4: big-endian words equal byte order (write side)
        for (int i = 0; i < 10; i++) seq[i] = 8'(8'h30 + 3 * i);
        cfg_wr_big = 1;
        for (int j = 0; j < 5; j++) host_write(1, {seq[2*j], seq[2*j+1]});
        for (int i = 0; i < 10; i++) begin
            sie_pop(b);
            check("R4 write word vs byte order", 32'(b), 32'(seq[i]));
        end

        // R4 + R10: read side big-endian, packet tracking
        for (int i = 0; i < 10; i++) begin
            sie_push(seq[i], i == 9, 0);
            if (i == 4) check("R10 ready low while filling", 32'(out_pkt_ready), 0);
        end
        check("R10 ready after end", 32'(out_pkt_ready), 1);
        check("R10 packet length", 32'(out_pkt_len), 10);
        check("R6 out_count", 32'(out_count), 10);
        cfg_rd_big = 1;
        for (int j = 0; j < 5; j++) begin
            host_read(1, d);
            check("R4 read word vs byte order", 32'(d), 32'({seq[2*j], seq[2*j+1]}));
        end
        check("R6 out_count drained", 32'(out_count), 0);

        // R3: little-endian read
        cfg_rd_big = 0;
        for (int i = 0; i < 4; i++) sie_push(8'(8'hA0 + i), i == 3, 0);
        host_read(1, d);
        check("R3 little read word 0", 32'(d), 32'h0000A1A0);
        host_read(1, d);
        check("R3 little read word 1", 32'(d), 32'h0000A3A2);

        // R5: odd tail, big then little
        cfg_rd_big = 1;
        sie_push(8'h5A, 0, 0); sie_push(8'h6B, 0, 0); sie_push(8'h7C, 1, 0);
        check("R10 length of 3", 32'(out_pkt_len), 3);
        host_read(1, d);
        check("R5 big pair", 32'(d), 32'h00005A6B);
        host_read(1, d);
        check("R5 big single byte", 32'(d), 32'h00007C00);
        check("R5 big single pops one", 32'(out_count), 0);
        check("R5 no underrun", 32'(out_underrun), 0);
        cfg_rd_big = 0;
        sie_push(8'hC3, 0, 0); sie_push(8'hD4, 1, 0);
        host_read(0, d);
        check("R1 byte read", 32'(d), 32'h000000C3);
        host_read(1, d);
        check("R5 little single byte", 32'(d), 32'h000000D4);
        check("R5 little single pops one", 32'(out_count), 0);

        // R8: read when empty
        host_read(1, d);
        check("R8 empty read data", 32'(d), 0);
        check("R8 underrun set", 32'(out_underrun), 1);
        check("R8 count unchanged", 32'(out_count), 0);
        sie_push(8'h42, 1, 0);
        host_read(0, d);
        check("R8 underrun sticky", 32'(out_underrun), 1);
        check("R1 byte after underrun", 32'(d), 32'h42);
        pulse_clr;
        check("R9 clr clears underrun", 32'(out_underrun), 0);
        check("R9 clr idle", 32'(out_pkt_ready), 0);

        // R9: data error sticky, readable while unloading, clr flushes
        sie_push(8'h01, 0, 0);
        sie_push(8'h02, 0, 1);
        sie_push(8'h03, 1, 0);
        check("R9 err set", 32'(out_data_err), 1);
        host_read(0, d);
        check("R9 err held while unloading", 32'(out_data_err), 1);
        check("R9 data still delivered", 32'(d), 32'h01);
        pulse_clr;
        check("R9 err cleared", 32'(out_data_err), 0);
        check("R9 OUT flushed", 32'(out_count), 0);
        check("R9 length cleared", 32'(out_pkt_len), 0);

        // R10: zero-length packet, and byte with end latched
        sie_out_end = 1; tick; sie_out_end = 0;
        check("R10 zero-length ready", 32'(out_pkt_ready), 1);
        check("R10 zero length", 32'(out_pkt_len), 0);
        sie_push(8'h99, 0, 0);
        check("R10 restart to fill", 32'(out_pkt_ready), 0);
        sie_push(8'h98, 1, 0);
        check("R10 length two", 32'(out_pkt_len), 2);
        pulse_clr;

        // R6: OUT full drops extra engine bytes
        for (int i = 0; i < 66; i++) sie_push(8'(i), 0, 0);
        check("R6 OUT capped at 64", 32'(out_count), 64);
        for (int i = 0; i < 64; i++) begin
            host_read(0, d);
            if (i == 0 || i == 63) check("R6 OUT content", 32'(d), 32'(8'(i)));
        end
        pulse_clr;

        // R7: IN overrun
        pulse_flush;
        for (int i = 0; i < 64; i++) host_write(0, 16'(i));
        check("R7 IN full", 32'(in_count), 64);
        check("R7 no overrun yet", 32'(in_overrun), 0);
        host_write(0, 16'h00FF);
        check("R7 full write ignored", 32'(in_count), 64);
        check("R7 overrun set", 32'(in_overrun), 1);
        sie_pop(b);
        check("R7 head unchanged", 32'(b), 0);
        pulse_flush;
        check("R7 flush clears overrun", 32'(in_overrun), 0);
        check("R7 flush empties", 32'(in_count), 0);
        for (int i = 0; i < 63; i++) host_write(0, 16'(i));
        host_write(1, 16'hBEEF);
        check("R7 word at 63 ignored", 32'(in_count), 63);
        check("R7 word overrun", 32'(in_overrun), 1);
        pulse_flush;

        finish_run;
    end
endmodule